// File: doc/BRIEF.md
# Test Access Port Controller

This block is the sequencing core of a boundary-scan test port. It follows a 16-state graph. A rising edge of the test clock moves it from state to state, and the mode-select line sampled on that edge chooses the next state. The graph has a reset state, an idle state, and two parallel scan branches: one for the data path and one for the instruction path. In each branch the walk goes through select, capture, shift, exit, pause, a second exit and update.

The controller drives no register itself. It issues registered strobes that the surrounding instruction register, data registers and serial output multiplexer act on. These are capture, shift and update for each branch, a test-logic reset level, and an enable for the serial output driver. All strobes are retimed onto the falling edge of the test clock. Each strobe is therefore steady across the rising edge at which a register shifts or captures. An active-low asynchronous test reset forces the reset state at any time. Its release passes through a short synchroniser. The current state is brought out for debug.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low, `state_o` reads 0 (reset state) and the strobes hold their reset values without waiting for a clock edge: `logic_reset` = 1 and every other strobe = 0.
- R2: After `trst_n` rises, the first SYNC_STAGES (default 2) rising edges of `tck` leave the state at 0 whatever `tms` is. From the next edge on, the state follows `tms`.
- R3: `state_o` changes only at a rising edge of `tck`, using the `tms` value sampled there. The encoding is: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR.
- R4: Data branch transitions:
  - capture goes to shift on 0 and to exit1 on 1.
  - shift holds on 0 and goes to exit1 on 1.
  - exit1 goes to pause on 0 and to update on 1.
  - pause holds on 0 and goes to exit2 on 1.
  - exit2 goes to shift on 0 and to update on 1.
  - update goes to idle on 0 and to select-DR on 1.
- R5: The instruction branch (states 10 to 15) makes the same moves as R4 among its own states, and update-IR also returns to idle on 0 or to select-DR on 1. Select-IR goes to capture-IR on 0 and to the reset state on 1.
- R6: The reset state holds on 1 and goes to idle on 0. Idle holds on 0 and goes to select-DR on 1. Select-DR goes to capture-DR on 0 and to select-IR on 1.
- R7: Five consecutive rising edges with `tms` = 1 bring the controller to state 0 from any state.
- R8: Strobes change only at a falling edge of `tck`. Across each rising edge they keep the value set at the falling edge before it.
- R9: At each falling edge, each strobe is set high exactly when the state held then is its own state, and low otherwise:
  - `logic_reset` for reset.
  - `dr_capture`, `dr_shift` and `dr_update` for states 3, 4 and 8.
  - `ir_capture`, `ir_shift` and `ir_update` for states 10, 11 and 15.
- R10: `tdo_en` is high only from a falling edge in shift-DR or shift-IR until the next falling edge.
- R11: No more than one of the six capture, shift and update strobes is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge |
| state_o | output | 4 | Current controller state (debug) |
| dr_capture | output | 1 | Data register capture strobe |
| dr_shift | output | 1 | Data register shift strobe |
| dr_update | output | 1 | Data register update strobe |
| ir_capture | output | 1 | Instruction register capture strobe |
| ir_shift | output | 1 | Instruction register shift strobe |
| ir_update | output | 1 | Instruction register update strobe |
| logic_reset | output | 1 | Test logic reset level |
| tdo_en | output | 1 | Serial output driver enable |

## Verification
On every edge, the assertions check four things:
- The exits from capture-DR.
- The escape from select-IR to reset.
- The return to reset after five high mode-select edges.
- The rules that tie the output enable to the shift strobes and keep the path strobes mutually exclusive.

Only the bench's scenarios show the rest: every one of the 32 arcs, the half-cycle lag of the strobes behind the state, the stability of the strobes across the rising edge, the asynchronous entry into reset and the edges ignored while the reset release is synchronised.

// File: rtl/tap_ctrl_pkg.sv
package tap_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_RESET  = 4'd0,
    ST_IDLE   = 4'd1,
    ST_DR_SEL = 4'd2,
    ST_DR_CAP = 4'd3,
    ST_DR_SH  = 4'd4,
    ST_DR_EX1 = 4'd5,
    ST_DR_PAU = 4'd6,
    ST_DR_EX2 = 4'd7,
    ST_DR_UPD = 4'd8,
    ST_IR_SEL = 4'd9,
    ST_IR_CAP = 4'd10,
    ST_IR_SH  = 4'd11,
    ST_IR_EX1 = 4'd12,
    ST_IR_PAU = 4'd13,
    ST_IR_EX2 = 4'd14,
    ST_IR_UPD = 4'd15
  } tap_state_e;

  typedef struct packed {
    logic tdo_en;
    logic logic_reset;
    logic ir_update;
    logic ir_shift;
    logic ir_capture;
    logic dr_update;
    logic dr_shift;
    logic dr_capture;
  } tap_strb_t;

endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/tap_next_state.sv
module tap_next_state
  import tap_ctrl_pkg::*;
(
  input  tap_state_e cur_i,
  input  logic       tms_i,
  output tap_state_e nxt_o
);

  always_comb begin
    nxt_o = cur_i;
    unique case (cur_i)
      ST_RESET:  nxt_o = tms_i ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt_o = tms_i ? ST_DR_SEL : ST_IDLE;
      ST_DR_SEL: nxt_o = tms_i ? ST_IR_SEL : ST_DR_CAP;
      ST_DR_CAP: nxt_o = tms_i ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_SH:  nxt_o = tms_i ? ST_DR_EX1 : ST_DR_SH;
      ST_DR_EX1: nxt_o = tms_i ? ST_DR_UPD : ST_DR_PAU;
      ST_DR_PAU: nxt_o = tms_i ? ST_DR_EX2 : ST_DR_PAU;
      ST_DR_EX2: nxt_o = tms_i ? ST_DR_UPD : ST_DR_SH;
      ST_DR_UPD: nxt_o = tms_i ? ST_DR_SEL : ST_IDLE;
      ST_IR_SEL: nxt_o = tms_i ? ST_RESET  : ST_IR_CAP;
      ST_IR_CAP: nxt_o = tms_i ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_SH:  nxt_o = tms_i ? ST_IR_EX1 : ST_IR_SH;
      ST_IR_EX1: nxt_o = tms_i ? ST_IR_UPD : ST_IR_PAU;
      ST_IR_PAU: nxt_o = tms_i ? ST_IR_EX2 : ST_IR_PAU;
      ST_IR_EX2: nxt_o = tms_i ? ST_IR_UPD : ST_IR_SH;
      ST_IR_UPD: nxt_o = tms_i ? ST_DR_SEL : ST_IDLE;
      default:   nxt_o = ST_RESET;
    endcase
  end

endmodule

// File: rtl/tap_strobe_gen.sv
module tap_strobe_gen
  import tap_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  tap_state_e state_i,
  output tap_strb_t  strb_o
);

  tap_strb_t strb_d;
  tap_strb_t strb_q;

  always_comb begin
    strb_d             = '0;
    strb_d.logic_reset = (state_i == ST_RESET);
    strb_d.dr_capture  = (state_i == ST_DR_CAP);
    strb_d.dr_shift    = (state_i == ST_DR_SH);
    strb_d.dr_update   = (state_i == ST_DR_UPD);
    strb_d.ir_capture  = (state_i == ST_IR_CAP);
    strb_d.ir_shift    = (state_i == ST_IR_SH);
    strb_d.ir_update   = (state_i == ST_IR_UPD);
    strb_d.tdo_en      = (state_i == ST_DR_SH) || (state_i == ST_IR_SH);
  end

  // Falling-edge retiming: strobes are steady across the rising edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q             <= '0;
      strb_q.logic_reset <= 1'b1;
    end else begin
      strb_q <= strb_d;
    end
  end

  assign strb_o = strb_q;

  assert_tdo_en_in_shift_R10: assert property (@(negedge clk) disable iff (!rst_n)
    strb_q.tdo_en |-> (strb_q.dr_shift || strb_q.ir_shift));

  assert_path_strobes_onehot0_R11: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0({strb_q.dr_capture, strb_q.dr_shift, strb_q.dr_update,
              strb_q.ir_capture, strb_q.ir_shift, strb_q.ir_update}));

endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output logic [3:0] state_o,
  output logic       dr_capture,
  output logic       dr_shift,
  output logic       dr_update,
  output logic       ir_capture,
  output logic       ir_shift,
  output logic       ir_update,
  output logic       logic_reset,
  output logic       tdo_en
);

  localparam int OnesToReset = 5;

  logic       rst_n_int;
  tap_state_e state_q;
  tap_state_e state_d;
  tap_strb_t  strb;

  tap_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_n_int)
  );

  tap_next_state u_next (
    .cur_i (state_q),
    .tms_i (tms),
    .nxt_o (state_d)
  );

  always_ff @(posedge tck or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= ST_RESET;
    else            state_q <= state_d;
  end

  tap_strobe_gen u_strb (
    .clk     (tck),
    .rst_n   (rst_n_int),
    .state_i (state_q),
    .strb_o  (strb)
  );

  assign state_o     = state_q;
  assign dr_capture  = strb.dr_capture;
  assign dr_shift    = strb.dr_shift;
  assign dr_update   = strb.dr_update;
  assign ir_capture  = strb.ir_capture;
  assign ir_shift    = strb.ir_shift;
  assign ir_update   = strb.ir_update;
  assign logic_reset = strb.logic_reset;
  assign tdo_en      = strb.tdo_en;

  // Checker-side count of consecutive high mode-select edges.
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge rst_n_int) begin
    if (!rst_n_int)                       ones_q <= '0;
    else if (!tms)                        ones_q <= '0;
    else if (ones_q != 3'(OnesToReset))   ones_q <= ones_q + 3'd1;
  end

  assert_five_ones_reset_R7: assert property (@(posedge tck) disable iff (!rst_n_int)
    (ones_q == 3'(OnesToReset)) |-> (state_q == ST_RESET));

  assert_capture_dr_exit_R4: assert property (@(posedge tck) disable iff (!rst_n_int)
    (state_q == ST_DR_CAP) |=> (state_q == ST_DR_SH || state_q == ST_DR_EX1));

  assert_ir_select_escape_R5: assert property (@(posedge tck) disable iff (!rst_n_int)
    (state_q == ST_IR_SEL && tms) |=> (state_q == ST_RESET));

endmodule

// File: tb/tap_ctrl_bench.sv
module tap_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;
  localparam int WATCHDOG   = 20000;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic [3:0] state_o;
  logic dr_capture, dr_shift, dr_update, ir_capture, ir_shift, ir_update;
  logic logic_reset, tdo_en;

  tap_ctrl #(.SYNC_STAGES(SYNC)) u_tap_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
    .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .ir_capture(ir_capture), .ir_shift(ir_shift), .ir_update(ir_update),
    .logic_reset(logic_reset), .tdo_en(tdo_en)
  );

  always #(CLK_PERIOD/2) tck = ~tck;

  logic [7:0] strb_vec;
  assign strb_vec = {tdo_en, logic_reset, ir_update, ir_shift, ir_capture,
                     dr_update, dr_shift, dr_capture};

  int n_vec = 0;
  int n_bad = 0;
  int m_state = 0;
  int rel_cnt = 0;
  logic [7:0] m_strb = 8'h40;
  bit done = 0;

  // Reference graph: int states, queue of {tms=0, tms=1} successors.
  function automatic int ref_next(int s, bit t);
    int succ[16][2] = '{ '{1,0}, '{1,2}, '{3,9}, '{4,5}, '{4,5}, '{6,8},
                         '{6,7}, '{4,8}, '{1,2}, '{10,0}, '{11,12}, '{11,12},
                         '{13,15}, '{13,14}, '{11,15}, '{1,2} };
    return succ[s][t];
  endfunction

  function automatic logic [7:0] ref_strb(int s);
    logic [7:0] v = 8'h00;
    if (s == 0)  v[6] = 1'b1;
    if (s == 3)  v[0] = 1'b1;
    if (s == 4)  v[1] = 1'b1;
    if (s == 8)  v[2] = 1'b1;
    if (s == 10) v[3] = 1'b1;
    if (s == 11) v[4] = 1'b1;
    if (s == 15) v[5] = 1'b1;
    if (s == 4 || s == 11) v[7] = 1'b1;
    return v;
  endfunction

  function automatic string tag_of(int s);
    if (s >= 3 && s <= 8)  return "R4";
    if (s >= 9)            return "R5";
    return "R6";
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Entered just after a falling edge; returns just after the next one.
  task automatic step(bit t);
    int prev;
    string tg;
    tms = t;
    @(posedge tck);
    prev = m_state;
    if (!trst_n) tg = "R1";
    else if (rel_cnt < SYNC) begin rel_cnt++; tg = "R2"; end
    else begin m_state = ref_next(m_state, t); tg = tag_of(prev); end
    #1;
    chk(state_o == m_state[3:0], tg, "state after rising edge", state_o, m_state);
    chk(strb_vec == m_strb, "R8", "strobes held across rising edge", strb_vec, m_strb);
    tms = ~t;
    @(negedge tck);
    #1;
    chk(state_o == m_state[3:0], "R3", "state stable at falling edge", state_o, m_state);
    m_strb = ref_strb(m_state);
    chk(strb_vec == m_strb, "R9", "strobes after falling edge", strb_vec, m_strb);
    chk(tdo_en == (m_state == 4 || m_state == 11), "R10", "tdo_en", tdo_en, m_strb[7]);
    chk($countones(strb_vec[5:0]) <= 1, "R11", "path strobes exclusive",
        $countones(strb_vec[5:0]), 1);
  endtask

  task automatic goto(int target);
    int len;
    logic [7:0] bits;
    case (target)
      1:  begin len = 1; bits = 8'b0;       end
      2:  begin len = 2; bits = 8'b01;      end
      3:  begin len = 3; bits = 8'b010;     end
      4:  begin len = 4; bits = 8'b0100;    end
      5:  begin len = 4; bits = 8'b0101;    end
      6:  begin len = 5; bits = 8'b01010;   end
      7:  begin len = 6; bits = 8'b010101;  end
      8:  begin len = 5; bits = 8'b01011;   end
      9:  begin len = 3; bits = 8'b011;     end
      10: begin len = 4; bits = 8'b0110;    end
      11: begin len = 5; bits = 8'b01100;   end
      12: begin len = 5; bits = 8'b01101;   end
      13: begin len = 6; bits = 8'b011010;  end
      14: begin len = 7; bits = 8'b0110101; end
      15: begin len = 6; bits = 8'b011011;  end
      default: begin len = 0; bits = 8'b0;  end
    endcase
    repeat (5) step(1'b1);
    for (int i = len - 1; i >= 0; i--) step(bits[i]);
    chk(state_o == target[3:0], "R3", "navigation", state_o, target);
  endtask

  task automatic pulse_trst();
    trst_n = 1'b0;
    #1;
    m_state = 0;
    rel_cnt = 0;
    m_strb = ref_strb(0);
    chk(state_o == 4'd0, "R1", "async reset state", state_o, 0);
    chk(strb_vec == m_strb, "R1", "async reset strobes", strb_vec, m_strb);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge tck);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    repeat (3) @(negedge tck);
    #1;
    chk(state_o == 4'd0, "R1", "reset state", state_o, 0);
    chk(strb_vec == 8'h40, "R1", "reset strobes", strb_vec, 8'h40);
    step(1'b0);
    trst_n = 1'b1;
    // R2: these edges are ignored even with tms low
    repeat (SYNC) step(1'b0);
    chk(state_o == 4'd0, "R2", "held during release", state_o, 0);
    step(1'b0);
    chk(state_o == 4'd1, "R2", "first live edge", state_o, 1);

    // Every arc of the graph (R4, R5, R6)
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 2; b++) begin
        goto(s);
        step(b[0]);
      end
    end

    // R7: five high edges from every state
    for (int s = 0; s < 16; s++) begin
      goto(s);
      repeat (5) step(1'b1);
      chk(state_o == 4'd0, "R7", "five ones to reset", state_o, 0);
    end

    // Long shifts and pauses
    goto(4);  repeat (9) step(1'b0);
    goto(13); repeat (6) step(1'b0);
    step(1'b1); step(1'b0); repeat (4) step(1'b0);

    // Asynchronous reset in the middle of an instruction shift (R1)
    goto(11);
    pulse_trst();
    step(1'b0);
    trst_n = 1'b1;
    repeat (SYNC + 3) step(1'b0);

    // Pseudo-random walk
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & (lfsr[3] | lfsr[7]));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule